// File: doc/BRIEF.md
# Half-Precision Predicate Comparator

This block compares two binary16 operands under one of ten predicates picked by a 4-bit code. It returns a single boolean and an invalid-operation status bit, both registered one clock after the operands are presented. It is meant to sit behind a vector lane and feed a mask bit plus a per-lane exception flag into whatever accumulates them.

The predicates fall into an ordered family, which is false whenever a NaN is involved, and an unordered family, which is true whenever a NaN is involved. Separately, each predicate is either quiet or signalling. A signalling NaN always raises invalid. A quiet NaN raises invalid only for the signalling predicates: the two ordered relationals and the two signalling unordered relationals. Ordering works on a monotonic key built from the sign-magnitude encoding, with both zeros folded to one key so that +0 and -0 compare equal.

Top module: `fp_pred_compare`

## Requirements
- R1: While `rst_n` is low, `result` and `invalid` are 0.
- R2: `result` and `invalid` reflect the operands and code sampled at the previous rising clock edge and hold until the next edge.
- R3: Predicate codes are 0 oeq, 1 ole, 2 olt, 3 ueq, 4 ule, 5 ult, 6 uleq, 7 ultq, 8 uneq, 9 un. For non-NaN operands, ordered codes 0-2 give a==b, a<=b and a<b.
- R4: For non-NaN operands, codes 3, 4, 5, 6, 7 and 8 give a==b, a<=b, a<b, a<=b, a<b and a!=b.
- R5: A NaN is a value with an all-ones exponent and a nonzero mantissa. Codes 0-2 give 0 if either operand is a NaN.
- R6: Codes 3-9 give 1 if either operand is a NaN.
- R7: Code 9 is 1 exactly when at least one operand is a NaN.
- R8: +0 (0x0000) and -0 (0x8000) compare equal to each other, and neither is less than the other, under every equality and relational predicate.
- R9: A NaN whose mantissa MSB is 1 is quiet. With a quiet NaN and no signalling NaN on the inputs, codes 1, 2, 6 and 7 set `invalid`.
- R10: With a quiet NaN and no signalling NaN on the inputs, codes 0, 3, 4, 5, 8 and 9 leave `invalid` at 0. With no NaN on the inputs, `invalid` is 0 for every code.
- R11: A NaN whose mantissa MSB is 0 is signalling. If either operand is a signalling NaN, codes 0-9 set `invalid`.
- R12: Codes 10-15 give `result` 0 and `invalid` 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | Left operand, binary16 |
| op_b | input | 16 | Right operand, binary16 |
| pred_sel | input | 4 | Predicate code |
| result | output | 1 | Registered predicate outcome |
| invalid | output | 1 | Registered invalid-operation status |

## Verification
Uniform random bit patterns almost never hit the cases that matter. An all-ones exponent shows up about once in thirty-two draws, a signalling NaN with a particular sign even less often, and two equal operands or a +0/-0 pair essentially never. The random generator therefore builds each operand from a weighted menu: quiet NaNs with random payloads, signalling NaNs with payloads forced nonzero, signed zeros, infinities, an exact copy of the other operand, and free bit patterns. The codes are drawn over the full 4-bit range so that unused codes also get NaN inputs. Directed passes cover the 2/3 reference matrix, every code against a quiet and a signalling NaN, and both zero orderings.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   typedef enum logic [3:0] {
      PR_OEQ  = 4'd0,
      PR_OLE  = 4'd1,
      PR_OLT  = 4'd2,
      PR_UEQ  = 4'd3,
      PR_ULE  = 4'd4,
      PR_ULT  = 4'd5,
      PR_ULEQ = 4'd6,
      PR_ULTQ = 4'd7,
      PR_UNEQ = 4'd8,
      PR_UN   = 4'd9
   } pred_e;

   localparam int unsigned PRED_COUNT = 10;

   typedef struct packed {
      logic nan;
      logic snan;
      logic zero;
   } class_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int unsigned EXP_W = 5,
   parameter int unsigned MAN_W = 10
) (
   input  logic [EXP_W+MAN_W:0] value,
   output fpcmp_pkg::class_t    cls
);
   localparam int unsigned W = EXP_W + MAN_W + 1;

   logic exp_ones;
   logic man_nz;
   logic mag_nz;

   assign exp_ones = &value[W-2:MAN_W];
   assign man_nz   = |value[MAN_W-1:0];
   assign mag_nz   = |value[W-2:0];

   assign cls.nan  = exp_ones & man_nz;
   assign cls.snan = exp_ones & man_nz & ~value[MAN_W-1];
   assign cls.zero = ~mag_nz;
endmodule

// File: rtl/fpcmp_key.sv
module fpcmp_key #(
   parameter int unsigned EXP_W = 5,
   parameter int unsigned MAN_W = 10
) (
   input  logic [EXP_W+MAN_W:0] value,
   input  logic                 is_zero,
   output logic [EXP_W+MAN_W:0] key
);
   localparam int unsigned W = EXP_W + MAN_W + 1;

   logic [W-1:0] canon;

   // both zeros fold onto +0 so they share one key
   assign canon = is_zero ? '0 : value;

   always_comb begin
      if (canon[W-1]) key = ~canon;
      else            key = {1'b1, canon[W-2:0]};
   end
endmodule

// File: rtl/fpcmp_eval.sv
module fpcmp_eval #(
   parameter int unsigned W = 16
) (
   input  logic [3:0]        pred_code,
   input  fpcmp_pkg::class_t cls_a,
   input  fpcmp_pkg::class_t cls_b,
   input  logic [W-1:0]      key_a,
   input  logic [W-1:0]      key_b,
   output logic              hit,
   output logic              inv
);
   import fpcmp_pkg::*;

   pred_e pr;
   logic  unord;
   logic  any_snan;
   logic  k_eq;
   logic  k_lt;
   logic  code_ok;
   logic  sig_pred;

   assign pr       = pred_e'(pred_code);
   assign unord    = cls_a.nan | cls_b.nan;
   assign any_snan = cls_a.snan | cls_b.snan;
   assign k_eq     = (key_a == key_b);
   assign k_lt     = (key_a < key_b);
   assign code_ok  = (32'(pred_code) < PRED_COUNT);

   always_comb begin
      case (pr)
         PR_OEQ:  hit = ~unord & k_eq;
         PR_OLE:  hit = ~unord & (k_lt | k_eq);
         PR_OLT:  hit = ~unord & k_lt;
         PR_UEQ:  hit = unord | k_eq;
         PR_ULE:  hit = unord | k_lt | k_eq;
         PR_ULT:  hit = unord | k_lt;
         PR_ULEQ: hit = unord | k_lt | k_eq;
         PR_ULTQ: hit = unord | k_lt;
         PR_UNEQ: hit = unord | ~k_eq;
         PR_UN:   hit = unord;
         default: hit = 1'b0;
      endcase
   end

   always_comb begin
      case (pr)
         PR_OLE, PR_OLT, PR_ULEQ, PR_ULTQ: sig_pred = 1'b1;
         default:                          sig_pred = 1'b0;
      endcase
   end

   assign inv = code_ok & (any_snan | (unord & sig_pred));
endmodule

// File: rtl/fp_pred_compare.sv
module fp_pred_compare #(
   parameter int unsigned EXP_W = 5,
   parameter int unsigned MAN_W = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [EXP_W+MAN_W:0]   op_a,
   input  logic [EXP_W+MAN_W:0]   op_b,
   input  logic [3:0]             pred_sel,
   output logic                   result,
   output logic                   invalid
);
   import fpcmp_pkg::*;

   localparam int unsigned W     = EXP_W + MAN_W + 1;
   localparam int unsigned N_OPS = 2;

   if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
      $error("fp_pred_compare: exponent and mantissa need at least two bits");
   end

   logic [W-1:0] opnd [N_OPS];
   logic [W-1:0] key  [N_OPS];
   class_t       cls  [N_OPS];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   for (genvar gi = 0; gi < N_OPS; gi++) begin : g_opnd
      fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls (
         .value (opnd[gi]),
         .cls   (cls[gi])
      );
      fpcmp_key #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_key (
         .value   (opnd[gi]),
         .is_zero (cls[gi].zero),
         .key     (key[gi])
      );
   end

   logic hit_c;
   logic inv_c;

   fpcmp_eval #(.W(W)) i_eval (
      .pred_code (pred_sel),
      .cls_a     (cls[0]),
      .cls_b     (cls[1]),
      .key_a     (key[0]),
      .key_b     (key[1]),
      .hit       (hit_c),
      .inv       (inv_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result  <= 1'b0;
         invalid <= 1'b0;
      end else begin
         result  <= hit_c;
         invalid <= inv_c;
      end
   end

   // ---- checks on the registered outputs against classifier facts ----
   logic primed;
   logic nan_any;
   logic snan_any;
   logic both_zero;

   assign nan_any   = cls[0].nan | cls[1].nan;
   assign snan_any  = cls[0].snan | cls[1].snan;
   assign both_zero = cls[0].zero & cls[1].zero;

   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(!rst_n) && primed == 1'b0 |-> !result && !invalid);

   assert_ordered_nan_false_R5: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(nan_any) && $past(pred_sel) <= 4'd2 |-> !result);

   assert_unordered_nan_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(nan_any) && $past(pred_sel) >= 4'd3 && $past(pred_sel) <= 4'd9 |-> result);

   assert_un_tracks_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(pred_sel) == 4'd9 |-> result == $past(nan_any));

   assert_zeros_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(both_zero) && $past(pred_sel) == 4'd0 |-> result);

   assert_no_nan_no_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      primed && !$past(nan_any) |-> !invalid);

   assert_snan_signals_R11: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(snan_any) && $past(pred_sel) <= 4'd9 |-> invalid);

   assert_unused_code_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(pred_sel) >= 4'd10 |-> !result && !invalid);
endmodule

// File: tb/test_fp_pred_compare.sv
`timescale 1ns/1ps
module test_fp_pred_compare;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic [3:0]  pred_sel = '0;
   logic        result;
   logic        invalid;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   fp_pred_compare i_fp_pred_compare (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .pred_sel(pred_sel), .result(result), .invalid(invalid)
   );

   function automatic bit f_nan(input logic [15:0] v);
      return (v[14:10] == 5'h1f) && (v[9:0] != 0);
   endfunction
   function automatic bit f_snan(input logic [15:0] v);
      return f_nan(v) && !v[9];
   endfunction
   function automatic bit f_zero(input logic [15:0] v);
      return v[14:0] == 0;
   endfunction

   function automatic bit f_eq(input logic [15:0] a, input logic [15:0] b);
      return (a == b) || (f_zero(a) && f_zero(b));
   endfunction
   function automatic bit f_lt(input logic [15:0] a, input logic [15:0] b);
      if (f_zero(a) && f_zero(b)) return 0;
      if (a[15] != b[15]) return a[15];
      if (!a[15]) return a[14:0] < b[14:0];
      return a[14:0] > b[14:0];
   endfunction

   function automatic bit exp_res(input logic [15:0] a, input logic [15:0] b, input int p);
      bit u = f_nan(a) || f_nan(b);
      bit e = f_eq(a, b);
      bit l = f_lt(a, b);
      case (p)
         0: return !u && e;
         1: return !u && (l || e);
         2: return !u && l;
         3: return u || e;
         4, 6: return u || l || e;
         5, 7: return u || l;
         8: return u || !e;
         9: return u;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_inv(input logic [15:0] a, input logic [15:0] b, input int p);
      if (p > 9) return 0;
      if (f_snan(a) || f_snan(b)) return 1;
      if (f_nan(a) || f_nan(b)) return (p == 1 || p == 2 || p == 6 || p == 7);
      return 0;
   endfunction

   function automatic string res_tag(input logic [15:0] a, input logic [15:0] b, input int p);
      if (p > 9) return "R12";
      if (p == 9) return "R7";
      if (f_nan(a) || f_nan(b)) return (p <= 2) ? "R5" : "R6";
      if (f_zero(a) && f_zero(b)) return "R8";
      return (p <= 2) ? "R3" : "R4";
   endfunction

   function automatic string inv_tag(input logic [15:0] a, input logic [15:0] b, input int p);
      if (p > 9) return "R12";
      if (f_snan(a) || f_snan(b)) return "R11";
      if (f_nan(a) || f_nan(b)) return (p == 1 || p == 2 || p == 6 || p == 7) ? "R9" : "R10";
      return "R10";
   endfunction

   task automatic check(input string tag, input string what, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s a=%h b=%h code=%0d actual=%b expected=%b",
                  tag, what, op_a, op_b, pred_sel, got, exp);
      end
   endtask

   // drive on a falling edge, capture on the rising edge, sample on the next falling edge
   task automatic apply(input logic [15:0] a, input logic [15:0] b, input int p);
      @(negedge clk);
      op_a = a; op_b = b; pred_sel = 4'(p);
      @(negedge clk);
      check(res_tag(a, b, p), "result", result, exp_res(a, b, p));
      check(inv_tag(a, b, p), "invalid", invalid, exp_inv(a, b, p));
   endtask

   function automatic logic [15:0] pick_val(input logic [15:0] other);
      logic [15:0] r = 16'($urandom);
      case ($urandom % 9)
         0, 1: return r;
         2: return {r[15], 5'h1f, 1'b1, r[8:0]};
         3: return {r[15], 5'h1f, 1'b0, r[8:1], 1'b1};
         4: return {r[15], 15'h0};
         5: return {r[15], 15'h7c00};
         6: return other;
         7: return {r[15], 5'h0f, r[9:0]};
         default: return {~other[15], other[14:0]};
      endcase
   endfunction

   localparam logic [15:0] TWO = 16'h4000, THREE = 16'h4200;
   localparam logic [15:0] QNAN = 16'h7e00, SNAN = 16'h7c01;

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: outputs held at zero in reset even with a true predicate on the inputs
      op_a = QNAN; op_b = TWO; pred_sel = 4'd9;
      repeat (3) @(negedge clk);
      check("R1", "result", result, 1'b0);
      check("R1", "invalid", invalid, 1'b0);
      rst_n = 1'b1;

      // R3 R4: reference matrix on 2 and 3
      for (int p = 0; p < 10; p++) begin
         apply(TWO, THREE, p);
         apply(THREE, TWO, p);
         apply(TWO, TWO, p);
      end

      // R2: one-cycle latency and hold
      apply(TWO, THREE, 2);
      @(negedge clk);
      op_a = THREE; op_b = TWO; pred_sel = 4'd2;
      #1 check("R2", "result held", result, 1'b1);
      @(negedge clk);
      check("R2", "result updated", result, 1'b0);

      // R8: signed zeros in both orders for every code
      for (int p = 0; p < 10; p++) begin
         apply(16'h0000, 16'h8000, p);
         apply(16'h8000, 16'h0000, p);
      end

      // R9 R10 R11: quiet and signalling NaN on each side, every code
      for (int p = 0; p < 16; p++) begin
         apply(TWO, QNAN, p);
         apply(QNAN, TWO, p);
         apply(SNAN, TWO, p);
         apply(TWO, 16'hfd55, p);
         apply(QNAN, SNAN, p);
      end

      // R12: unused codes with ordinary operands
      for (int p = 10; p < 16; p++) apply(TWO, TWO, p);

      // mixed random stimulus
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a = pick_val(16'($urandom));
         logic [15:0] b = pick_val(a);
         apply(a, b, int'($urandom % 16));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule